// File: doc/BRIEF.md
# Speaker Enrol/Identify Master Sequencer

This block is the top-level controller of a speaker enrolment and identification system. It waits in an idle phase for an operator request. The request can be "enrol a new speaker" or "identify the current speaker". Either request starts a feature-extraction run. When the extractor reports completion, the controller branches on the mode it captured when it left idle:

- **Enrol:** it launches a sub-sequencer that stores features and waits until that sub-sequencer stops being busy.
- **Identify:** it launches a sub-sequencer that fetches features and a scoring sub-sequencer together. It returns to idle only when the fetch has gone idle and the scoring side has reported done.

The controller drives four status LEDs and a small display code that the display logic turns into text. After each completed run it shows an "enrol finished" or "identify finished" code for a fixed number of cycles. It then falls back to "ready". A reset request can be made at any time. It puts the controller into a reset phase, clears the status outputs and tells every sub-sequencer to reset.

Top module: `enrol_id_sequencer`

## Requirements
- R1: After `rst_n` is released, the block is idle with `disp_code_o` = 1 (ready) and `led_o` = 4'b0001. `extract_o`, `store_start_o`, `fetch_start_o`, `check_start_o` and `sub_reset_o` are all low.
- R2: Requests in idle start extraction:
  - A request sampled on `add_req_i` or `id_req_i` at a clock edge while idle makes `extract_o` high for exactly the next cycle.
  - From then on, `disp_code_o` = 2 (extracting) and `led_o` = 4'b0010.
  - If both requests are sampled together, the enrol request wins.
- R3: The mode is captured when the block leaves idle, and stray inputs have no effect:
  - Request inputs seen outside idle do not change the phase or the branch taken after extraction.
  - `extracted_i` seen while idle is ignored.
- R4: In enrol mode, the first edge that samples `extracted_i` high during extraction makes `store_start_o` high for exactly one cycle. The display then shows `disp_code_o` = 3 (enrolling) with `led_o` = 4'b0100.
- R5: The enrol phase ends at the first edge after the start cycle at which `store_busy_i` is low. After that, `disp_code_o` = 4 (enrol finished) for exactly `DONE_HOLD` cycles, and then 1 (ready). The LEDs show 4'b0001 throughout.
- R6: In identify mode, `extracted_i` makes `fetch_start_o` and `check_start_o` high together for exactly one cycle. The display then shows `disp_code_o` = 5 (identifying) with `led_o` = 4'b1000.
- R7: The identify phase ends at the first edge after the start cycle at which two conditions hold:
  - `fetch_busy_i` is low.
  - A `check_done_i` pulse has been seen during the phase. The pulse may be earlier than the edge or at the same edge.

  After that, `disp_code_o` = 6 (identify finished) for `DONE_HOLD` cycles, and then 1.
- R8: Reset requests:
  - A `reset_req_i` sampled high in any phase leads, from the next cycle, to `sub_reset_o` = 1, `led_o` = 0 and `disp_code_o` = 0.
  - This holds for as long as the request is sampled high.
  - The cycle after the request is released, the block is idle showing ready.
  - Any pending done indication is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_req_i | input | 1 | Enrol request (synchronised button) |
| id_req_i | input | 1 | Identify request (synchronised button) |
| reset_req_i | input | 1 | Operator reset request |
| extract_o | output | 1 | One-cycle pulse starting feature extraction |
| extracted_i | input | 1 | Extraction finished pulse |
| store_start_o | output | 1 | One-cycle start to the store sub-sequencer |
| store_busy_i | input | 1 | Store sub-sequencer busy |
| fetch_start_o | output | 1 | One-cycle start to the fetch sub-sequencer |
| fetch_busy_i | input | 1 | Fetch sub-sequencer busy |
| check_start_o | output | 1 | One-cycle start to the scoring sub-sequencer |
| check_done_i | input | 1 | Scoring finished pulse |
| sub_reset_o | output | 1 | Reset to all sub-sequencers while in the reset phase |
| led_o | output | 4 | Status LEDs {identifying, enrolling, extracting, ready} |
| disp_code_o | output | 3 | Display status code (0 blank … 6 identify finished) |

## Verification
The in-line properties watch three things on every cycle:
- the single-cycle width of each start pulse;
- the step from an idle request to extraction, and the capture of a score pulse into the sticky flag;
- the clearing of outputs after a reset request, and the rule that the identify phase cannot end while the fetch side is busy.

Some behaviours span many cycles and depend on ordering, so only the bench's scenarios can show them:
- the captured mode surviving stray button presses;
- the three orderings of the score pulse against the fall of fetch-busy;
- the exact length of the finished display;
- the sticky flag being discarded by a reset.

// File: rtl/eid_pkg.sv
package eid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RESET = 3'd1,
    ST_BUSY0 = 3'd2,
    ST_BUSY1 = 3'd3,
    ST_BUSY2 = 3'd4
  } eid_state_e;

  typedef enum logic {
    MODE_ADD   = 1'b0,
    MODE_IDENT = 1'b1
  } eid_mode_e;

  localparam int DISP_W = 3;
  localparam int LED_W  = 4;

  localparam logic [DISP_W-1:0] DISP_BLANK    = 3'd0;
  localparam logic [DISP_W-1:0] DISP_READY    = 3'd1;
  localparam logic [DISP_W-1:0] DISP_EXTRACT  = 3'd2;
  localparam logic [DISP_W-1:0] DISP_ADDING   = 3'd3;
  localparam logic [DISP_W-1:0] DISP_ADD_DONE = 3'd4;
  localparam logic [DISP_W-1:0] DISP_IDENT    = 3'd5;
  localparam logic [DISP_W-1:0] DISP_ID_DONE  = 3'd6;

  // LED pattern for a given display code: {ident, add, extract, ready}
  function automatic logic [LED_W-1:0] led_for(logic [DISP_W-1:0] code);
    logic [LED_W-1:0] l;
    case (code)
      DISP_READY, DISP_ADD_DONE, DISP_ID_DONE: l = 4'b0001;
      DISP_EXTRACT:                            l = 4'b0010;
      DISP_ADDING:                             l = 4'b0100;
      DISP_IDENT:                              l = 4'b1000;
      default:                                 l = '0;
    endcase
    return l;
  endfunction

  // Display code for a phase, with the finished-hold flag and its kind
  function automatic logic [DISP_W-1:0] disp_for(eid_state_e st, logic hold,
                                                 eid_mode_e kind);
    logic [DISP_W-1:0] c;
    case (st)
      ST_IDLE:  c = hold ? ((kind == MODE_ADD) ? DISP_ADD_DONE : DISP_ID_DONE)
                         : DISP_READY;
      ST_BUSY0: c = DISP_EXTRACT;
      ST_BUSY1: c = DISP_ADDING;
      ST_BUSY2: c = DISP_IDENT;
      default:  c = DISP_BLANK;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/eid_mode_latch.sv
module eid_mode_latch
  import eid_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  logic      add_req,
  input  logic      id_req,
  output logic      go,
  output eid_mode_e mode_q
);

  assign go = capture && (add_req || id_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mode_q <= MODE_ADD;
    else if (go)  mode_q <= add_req ? MODE_ADD : MODE_IDENT;
  end

  p_add_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && add_req) |=> (mode_q == MODE_ADD));

  p_mode_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture) |=> $stable(mode_q));

endmodule

// File: rtl/eid_join_tracker.sv
module eid_join_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,        // in identify phase and staying there
  input  logic done_pulse,
  output logic join_ok,
  output logic seen_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_q <= 1'b0;
    else if (arm)   seen_q <= seen_q | done_pulse;
    else            seen_q <= 1'b0;
  end

  assign join_ok = seen_q | done_pulse;

  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && done_pulse) |=> seen_q);

endmodule

// File: rtl/eid_status_gen.sv
module eid_status_gen
  import eid_pkg::*;
#(
  parameter int DONE_HOLD = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  eid_state_e         state,
  input  logic               fin_add,
  input  logic               fin_id,
  output logic [DISP_W-1:0]  disp_o,
  output logic [LED_W-1:0]   led_o
);

  localparam int HOLD_W = $clog2(DONE_HOLD + 1);

  logic [HOLD_W-1:0] hold_cnt_q;
  eid_mode_e         kind_q;
  logic              hold_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt_q <= '0;
      kind_q     <= MODE_ADD;
    end else if (fin_add || fin_id) begin
      hold_cnt_q <= HOLD_W'(DONE_HOLD);
      kind_q     <= fin_id ? MODE_IDENT : MODE_ADD;
    end else if (state == ST_IDLE && hold_cnt_q != '0) begin
      hold_cnt_q <= hold_cnt_q - 1'b1;
    end else if (state != ST_IDLE) begin
      hold_cnt_q <= '0;
    end
  end

  assign hold_live = (hold_cnt_q != '0);
  assign disp_o    = disp_for(state, hold_live, kind_q);
  assign led_o     = led_for(disp_o);

  p_hold_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && hold_cnt_q == 1 && !fin_add && !fin_id)
      |=> (disp_o != DISP_ADD_DONE && disp_o != DISP_ID_DONE));

endmodule

// File: rtl/enrol_id_sequencer.sv
module enrol_id_sequencer
  import eid_pkg::*;
#(
  parameter int DONE_HOLD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_req_i,
  input  logic              id_req_i,
  input  logic              reset_req_i,
  output logic              extract_o,
  input  logic              extracted_i,
  output logic              store_start_o,
  input  logic              store_busy_i,
  output logic              fetch_start_o,
  input  logic              fetch_busy_i,
  output logic              check_start_o,
  input  logic              check_done_i,
  output logic              sub_reset_o,
  output logic [LED_W-1:0]  led_o,
  output logic [DISP_W-1:0] disp_code_o
);

  eid_state_e state_q, state_n;
  eid_mode_e  mode_q;
  logic       entry_q;
  logic       go;
  logic       join_ok;
  logic       seen_q;
  logic       fin_add, fin_id;

  eid_mode_latch u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (state_q == ST_IDLE && !reset_req_i),
    .add_req (add_req_i),
    .id_req  (id_req_i),
    .go      (go),
    .mode_q  (mode_q)
  );

  eid_join_tracker u_join (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (state_q == ST_BUSY2 && state_n == ST_BUSY2),
    .done_pulse (check_done_i),
    .join_ok    (join_ok),
    .seen_q     (seen_q)
  );

  always_comb begin
    state_n = state_q;
    if (reset_req_i) begin
      state_n = ST_RESET;
    end else begin
      case (state_q)
        ST_IDLE:  if (go) state_n = ST_BUSY0;
        ST_RESET: state_n = ST_IDLE;
        ST_BUSY0: if (extracted_i)
                    state_n = (mode_q == MODE_ADD) ? ST_BUSY1 : ST_BUSY2;
        ST_BUSY1: if (!entry_q && !store_busy_i) state_n = ST_IDLE;
        ST_BUSY2: if (!entry_q && !fetch_busy_i && join_ok) state_n = ST_IDLE;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      entry_q <= 1'b0;
    end else begin
      state_q <= state_n;
      entry_q <= (state_n != state_q);
    end
  end

  assign fin_add = (state_q == ST_BUSY1) && (state_n == ST_IDLE);
  assign fin_id  = (state_q == ST_BUSY2) && (state_n == ST_IDLE);

  assign extract_o     = entry_q && (state_q == ST_BUSY0);
  assign store_start_o = entry_q && (state_q == ST_BUSY1);
  assign fetch_start_o = entry_q && (state_q == ST_BUSY2);
  assign check_start_o = entry_q && (state_q == ST_BUSY2);
  assign sub_reset_o   = (state_q == ST_RESET);

  eid_status_gen #(.DONE_HOLD(DONE_HOLD)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_q),
    .fin_add (fin_add),
    .fin_id  (fin_id),
    .disp_o  (disp_code_o),
    .led_o   (led_o)
  );

  p_extract_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    extract_o |=> !extract_o);

  p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && (add_req_i || id_req_i) && !reset_req_i) |=> extract_o);

  p_store_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    store_start_o |=> !store_start_o);

  p_add_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY1 && !store_start_o && !store_busy_i && !reset_req_i)
      |=> (disp_code_o == DISP_ADD_DONE));

  p_fetch_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start_o |=> (!fetch_start_o && !check_start_o));

  p_join_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY2 && fetch_busy_i && !reset_req_i) |=> (state_q == ST_BUSY2));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_i |=> (sub_reset_o && led_o == '0 && disp_code_o == DISP_BLANK && !seen_q));

endmodule

// File: tb/enrol_id_sequencer_bench.sv
`timescale 1ns/1ps
module enrol_id_sequencer_bench;

  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic add_req = 0, id_req = 0, reset_req = 0, extracted = 0;
  logic store_busy = 0, fetch_busy = 0, check_done = 0;
  logic extract, store_start, fetch_start, check_start, sub_reset;
  logic [3:0] led;
  logic [2:0] disp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  enrol_id_sequencer #(.DONE_HOLD(HOLD)) u_enrol_id_sequencer (
    .clk(clk), .rst_n(rst_n), .add_req_i(add_req), .id_req_i(id_req),
    .reset_req_i(reset_req), .extract_o(extract), .extracted_i(extracted),
    .store_start_o(store_start), .store_busy_i(store_busy),
    .fetch_start_o(fetch_start), .fetch_busy_i(fetch_busy),
    .check_start_o(check_start), .check_done_i(check_done),
    .sub_reset_o(sub_reset), .led_o(led), .disp_code_o(disp)
  );

  // bench's own view of the LED encoding per display code
  function automatic int exp_led(int code);
    case (code)
      1, 4, 6: return 1;
      2:       return 2;
      3:       return 4;
      5:       return 8;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_status(string tag, int code);
    chk({tag, " disp"}, disp, code);
    chk({tag, " led"}, led, exp_led(code));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_hold(string tag, int code);
    // first done cycle already sampled by caller
    for (int k = 1; k < HOLD; k++) begin
      tick();
      chk_status(tag, code);
    end
    tick();
    chk_status({tag, " back to ready"}, 1);
  endtask

  task automatic begin_run(bit both, bit ident, int lat, bit stray);
    add_req = both | !ident;
    id_req  = both | ident;
    tick();
    add_req = 0; id_req = 0;
    chk("R2 extract pulse", extract, 1);
    chk_status("R2 extracting", 2);
    for (int i = 0; i < lat; i++) begin
      add_req = stray & ident;
      id_req  = stray & !ident;
      tick();
      chk("R2 extract single", extract, 0);
      chk_status("R3 stray ignored", 2);
    end
    add_req = 0; id_req = 0;
    extracted = 1;
    tick();
    extracted = 0;
  endtask

  task automatic run_add(bit both, int lat, int busy, bit stray);
    begin_run(both, 0, lat, stray);
    chk("R4 store start", store_start, 1);
    chk("R3 no fetch in add", fetch_start, 0);
    chk_status("R4 enrolling", 3);
    store_busy = 1;
    tick();
    chk("R4 store pulse width", store_start, 0);
    for (int i = 0; i < busy; i++) begin
      id_req = stray;
      tick();
      chk_status("R5 wait busy", 3);
    end
    id_req = 0;
    store_busy = 0;
    tick();
    chk_status("R5 enrol finished", 4);
    chk_hold("R5 hold", 4);
  endtask

  // order: 0 done before busy falls, 1 together, 2 after
  task automatic run_id(int lat, int busy, int order, bit stray);
    begin_run(0, 1, lat, stray);
    chk("R6 fetch start", fetch_start, 1);
    chk("R6 check start", check_start, 1);
    chk("R3 no store in identify", store_start, 0);
    chk_status("R6 identifying", 5);
    fetch_busy = 1;
    tick();
    chk("R6 fetch pulse width", fetch_start, 0);
    chk("R6 check pulse width", check_start, 0);
    for (int i = 0; i < busy; i++) begin
      check_done = (order == 0 && i == busy / 2);
      add_req = stray;
      tick();
      chk_status("R7 wait join", 5);
    end
    check_done = 0; add_req = 0;
    if (order == 2) begin
      fetch_busy = 0;
      for (int i = 0; i < 3; i++) begin
        tick();
        chk_status("R7 await done", 5);
      end
      check_done = 1;
    end else if (order == 1) begin
      fetch_busy = 0;
      check_done = 1;
    end else begin
      fetch_busy = 0;
    end
    tick();
    check_done = 0;
    chk_status("R7 identify finished", 6);
    chk_hold("R7 hold", 6);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk_status("R1 reset state", 1);
    chk("R1 extract", extract, 0);
    chk("R1 starts", {store_start, fetch_start, check_start}, 0);
    chk("R1 sub reset", sub_reset, 0);

    // R3: extracted in idle ignored
    extracted = 1; tick(); extracted = 0; tick();
    chk_status("R3 extracted in idle", 1);
    chk("R3 no start", {store_start, fetch_start, check_start}, 0);

    // directed cases
    run_add(1, 2, 3, 0);        // R2 both requests: enrol wins
    run_add(0, 1, 1, 1);
    run_id(1, 4, 0, 1);
    run_id(2, 2, 1, 0);
    run_id(1, 1, 2, 1);

    // R8: reset during identify with score pulse already captured
    id_req = 1; tick(); id_req = 0;
    extracted = 1; tick(); extracted = 0;
    fetch_busy = 1; tick();
    check_done = 1; tick(); check_done = 0;
    reset_req = 1; tick();
    chk("R8 sub reset", sub_reset, 1);
    chk_status("R8 cleared", 0);
    tick();
    chk("R8 held sub reset", sub_reset, 1);
    chk_status("R8 held cleared", 0);
    reset_req = 0; fetch_busy = 0; tick();
    chk_status("R8 ready after release", 1);
    chk("R8 sub reset released", sub_reset, 0);
    run_id(1, 2, 2, 0);         // R8 sticky must have been discarded

    // R8: reset during the finished display
    add_req = 1; tick(); add_req = 0;
    extracted = 1; tick(); extracted = 0;
    tick(); tick();
    chk_status("R5 enrol finished short", 4);
    reset_req = 1; tick(); reset_req = 0;
    chk_status("R8 blank", 0);
    tick();
    chk_status("R8 hold discarded", 1);

    // constrained random transactions
    for (int t = 0; t < 40; t++) begin
      int lat, busy, order;
      bit stray, ident;
      lat   = 1 + int'($urandom % 6);
      busy  = 1 + int'($urandom % 8);
      order = int'($urandom % 3);
      stray = 1'($urandom % 2);
      ident = 1'($urandom % 2);
      if (ident) run_id(lat, busy, order, stray);
      else       run_add(0, lat, busy, stray);
      repeat (int'($urandom % 3)) tick();
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule